// File: doc/BRIEF.md
# Running-Disparity DC Balance Codec

This block keeps a serialized lane free of long-term DC bias by sending each data word either unchanged or with every bit flipped. The choice comes from the sign of a running disparity register and the disparity of the word being sent. An extra flag bit, set when the word was flipped, travels next to the data. The matching decoder uses that flag to restore the original word. The running disparity counts the flag bit as well as the data bits. It is clamped to the asymmetric window −6 to +7.

An enable input selects the mode. With balancing switched off, both sides pass words straight through, the flag bit stays 0 and the running disparity is frozen. The encoder and the decoder each have their own valid/data pair and are independent pipelines of one register each. A link instance uses the encoder on the transmit side and the decoder on the receive side.

Top module: `dcb_codec`

## Requirements
- R1: After synchronous reset both output valids are low, both output words are zero, and the running disparity is 0.
- R2: The encoded word is DATA_W+1 bits wide. Bit DATA_W is the flag (1 = data bits inverted, 0 = sent as-is) and bits DATA_W-1:0 carry the data.
- R3: When the running disparity is above zero, a word with positive disparity (ones minus zeros) is inverted and a word with zero or negative disparity is sent as-is.
- R4: When the running disparity is below zero, a word with positive disparity is sent as-is and a word with zero or negative disparity is inverted.
- R5: When the running disparity is exactly zero, the word is always inverted.
- R6: After an as-is word the running disparity grows by (word disparity − 1). After an inverted word it grows by (1 − word disparity).
- R7: The running disparity never leaves −6..+7, and a sum beyond either bound is clamped to that bound.
- R8: The running disparity and the encoder output change only in cycles where the encoder input valid is high.
- R9: With the enable low, the encoder emits {0, data} and leaves the running disparity unchanged.
- R10: The encoder output appears with its valid exactly one cycle after the input is accepted.
- R11: When enabled, the decoder outputs the data bits inverted if the flag is 1 and unchanged if it is 0, one cycle after the input. With the enable low it ignores the flag.
- R12: Feeding encoder output into the decoder returns every original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bal_en | input | 1 | Balancing mode enable |
| enc_valid_i | input | 1 | Encoder input word valid |
| enc_data_i | input | DATA_W | Encoder input data word |
| enc_valid_o | output | 1 | Encoder output valid |
| enc_word_o | output | DATA_W+1 | Encoded word: flag on top, data below |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_word_i | input | DATA_W+1 | Received encoded word |
| dec_valid_o | output | 1 | Decoder output valid |
| dec_data_o | output | DATA_W | Restored data word |

## Verification
Two things can happen in the same cycle: the encoder takes a new word while the decoder restores the word encoded one cycle earlier. A streaming test sets this up by feeding the encoder's output back into the decoder on every cycle of a long pseudo-random sequence. Each cycle it compares both outputs against a model written from the requirements. Directed sequences first drive the running disparity to exactly +7 and to exactly −6. The next decision then shows that the bound was held.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int LANE_W_DEF = 6;
    localparam int RD_W_DEF   = 4;
    localparam int RD_HI_DEF  = 7;
    localparam int RD_LO_DEF  = -6;

    typedef enum logic {
        SEND_TRUE = 1'b0,
        SEND_INV  = 1'b1
    } polarity_e;

endpackage

// File: rtl/dcb_disparity.sv
module dcb_disparity #(
    parameter int DATA_W = 6,
    parameter int DISP_W = 5
) (
    input  logic [DATA_W-1:0]        word_i,
    output logic signed [DISP_W-1:0] disp_o
);

    logic [DISP_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ones = ones + DISP_W'(word_i[i]);
        end
        disp_o = $signed((ones << 1) - DISP_W'(DATA_W));
    end

endmodule

// File: rtl/dcb_encoder.sv
module dcb_encoder
    import dcb_pkg::*;
#(
    parameter int DATA_W  = LANE_W_DEF,
    parameter int RD_W    = RD_W_DEF,
    parameter int RD_HI   = RD_HI_DEF,
    parameter int RD_LO   = RD_LO_DEF,
    parameter int INIT_RD = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W:0]   out_word
);

    localparam int DISP_W = $clog2(DATA_W + 1) + 2;
    localparam int SUM_W  = DISP_W + RD_W;

    localparam logic signed [SUM_W-1:0] HI_S   = SUM_W'(RD_HI);
    localparam logic signed [SUM_W-1:0] LO_S   = SUM_W'(RD_LO);
    localparam logic signed [SUM_W-1:0] ONE_S  = SUM_W'(1);
    localparam logic signed [RD_W-1:0]  INIT_S = RD_W'(INIT_RD);

    logic signed [RD_W-1:0]   rd_q, rd_d;
    logic signed [DISP_W-1:0] disp;
    logic signed [SUM_W-1:0]  disp_x, rd_x, delta, sum;
    polarity_e                pol;
    logic [DATA_W-1:0]        tx_data;

    dcb_disparity #(
        .DATA_W (DATA_W),
        .DISP_W (DISP_W)
    ) disp_i (
        .word_i (in_data),
        .disp_o (disp)
    );

    // Polarity decision from the signs of the running and word disparity
    always_comb begin
        disp_x = SUM_W'(disp);
        rd_x   = SUM_W'(rd_q);
        if (rd_q == '0) begin
            pol = SEND_INV;
        end else if (rd_q > 0) begin
            pol = (disp > 0) ? SEND_INV : SEND_TRUE;
        end else begin
            pol = (disp > 0) ? SEND_TRUE : SEND_INV;
        end
    end

    // Running disparity update, flag bit included, with clamping
    always_comb begin
        if (pol == SEND_INV) begin
            delta = ONE_S - disp_x;
        end else begin
            delta = disp_x - ONE_S;
        end
        sum = rd_x + delta;
        if (sum > HI_S) begin
            rd_d = RD_W'(HI_S);
        end else if (sum < LO_S) begin
            rd_d = RD_W'(LO_S);
        end else begin
            rd_d = RD_W'(sum);
        end
        tx_data = (pol == SEND_INV) ? ~in_data : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= INIT_S;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (en) begin
                    out_word <= {pol == SEND_INV, tx_data};
                    rd_q     <= rd_d;
                end else begin
                    out_word <= {1'b0, in_data};
                end
            end
        end
    end

    p_rd_range_r7: assert property (@(posedge clk) disable iff (rst)
        (SUM_W'(rd_q) <= HI_S) && (SUM_W'(rd_q) >= LO_S));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(rd_q) && $stable(out_word) && !out_valid);

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && !en |=> (out_word == {1'b0, $past(in_data)}) && $stable(rd_q));

    p_zero_inv_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && en && (rd_q == '0) |=> out_word[DATA_W] && (out_word[DATA_W-1:0] == ~$past(in_data)));

    p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

endmodule

// File: rtl/dcb_decoder.sv
module dcb_decoder #(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W:0]   in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              flip;
    logic [DATA_W-1:0] restored;

    always_comb begin
        flip     = en && in_word[DATA_W];
        restored = flip ? ~in_word[DATA_W-1:0] : in_word[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= restored;
            end
        end
    end

    p_restore_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid && en && in_word[DATA_W] |=> out_valid && (out_data == ~$past(in_word[DATA_W-1:0])));

    p_flag_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid && !en |=> out_data == $past(in_word[DATA_W-1:0]));

endmodule

// File: rtl/dcb_codec.sv
module dcb_codec
    import dcb_pkg::*;
#(
    parameter int DATA_W  = LANE_W_DEF,
    parameter int RD_W    = RD_W_DEF,
    parameter int RD_HI   = RD_HI_DEF,
    parameter int RD_LO   = RD_LO_DEF,
    parameter int INIT_RD = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bal_en,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [DATA_W:0]   enc_word_o,
    input  logic              dec_valid_i,
    input  logic [DATA_W:0]   dec_word_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o
);

    dcb_encoder #(
        .DATA_W  (DATA_W),
        .RD_W    (RD_W),
        .RD_HI   (RD_HI),
        .RD_LO   (RD_LO),
        .INIT_RD (INIT_RD)
    ) enc_i (
        .clk       (clk),
        .rst       (rst),
        .en        (bal_en),
        .in_valid  (enc_valid_i),
        .in_data   (enc_data_i),
        .out_valid (enc_valid_o),
        .out_word  (enc_word_o)
    );

    dcb_decoder #(
        .DATA_W (DATA_W)
    ) dec_i (
        .clk       (clk),
        .rst       (rst),
        .en        (bal_en),
        .in_valid  (dec_valid_i),
        .in_word   (dec_word_i),
        .out_valid (dec_valid_o),
        .out_data  (dec_data_o)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> !enc_valid_o && !dec_valid_o && (enc_word_o == '0) && (dec_data_o == '0));

endmodule

// File: tb/dcb_codec_tb_top.sv
`timescale 1ns/1ps
module dcb_codec_tb_top;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bal_en = 1'b1;
    logic         enc_valid_i = 1'b0;
    logic [W-1:0] enc_data_i = '0;
    logic         enc_valid_o;
    logic [W:0]   enc_word_o;
    logic         dec_valid_i = 1'b0;
    logic [W:0]   dec_word_i = '0;
    logic         dec_valid_o;
    logic [W-1:0] dec_data_o;

    int checks = 0;
    int fails  = 0;
    int rd_m   = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dcb_codec dut_i (
        .clk         (clk),
        .rst         (rst),
        .bal_en      (bal_en),
        .enc_valid_i (enc_valid_i),
        .enc_data_i  (enc_data_i),
        .enc_valid_o (enc_valid_o),
        .enc_word_o  (enc_word_o),
        .dec_valid_i (dec_valid_i),
        .dec_word_i  (dec_word_i),
        .dec_valid_o (dec_valid_o),
        .dec_data_o  (dec_data_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference from requirements R3..R7: returns encoded word, updates rd_m
    function automatic logic [W:0] model(input logic [W-1:0] d);
        int ones = 0;
        int disp;
        int nxt;
        bit inv;
        for (int i = 0; i < W; i++) ones += d[i];
        disp = 2 * ones - W;
        if (rd_m == 0)     inv = 1'b1;
        else if (rd_m > 0) inv = (disp > 0);
        else               inv = (disp <= 0);
        nxt = inv ? rd_m + 1 - disp : rd_m + disp - 1;
        if (nxt > 7)  nxt = 7;
        if (nxt < -6) nxt = -6;
        rd_m = nxt;
        return inv ? {1'b1, ~d} : {1'b0, d};
    endfunction

    task automatic send(input string req, input logic [W-1:0] d);
        logic [W:0] exp;
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        exp = bal_en ? model(d) : {1'b0, d};
        @(posedge clk);
        #1;
        enc_valid_i = 1'b0;
        check({req, " valid"}, int'(enc_valid_o), 1);
        check(req, int'(enc_word_o), int'(exp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            enc_valid_i = 1'b0;
            enc_data_i  = 6'h2A;
            dec_valid_i = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_m = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 enc valid", int'(enc_valid_o), 0);
        check("R1 enc word", int'(enc_word_o), 0);
        check("R1 dec valid", int'(dec_valid_o), 0);
        check("R1 dec data", int'(dec_data_o), 0);
        // R1/R5: disparity 0 after reset, so a balanced word gets inverted
        send("R1 R5 first word", 6'b000111);
        check("R2 flag set", int'(enc_word_o[W]), 1);
        check("R2 data", int'(enc_word_o[W-1:0]), 6'b111000);
    endtask

    task automatic t_rules();
        do_reset();
        send("R5 rd0", 6'b000111);      // rd -> 1
        send("R3 pos rd pos word", 6'b001111);  // inverted, rd -> 0
        check("R3 hand", int'(enc_word_o), 7'h70);
        send("R5 rd0 neg word", 6'b000001);     // inverted, rd -> 5
        send("R3 pos rd neg word", 6'b000011);  // as-is, rd -> 2
        check("R3 hand asis", int'(enc_word_o), 7'h03);
        send("R6 drive neg", 6'b111111);        // inverted, rd -> -3
        send("R4 neg rd pos word", 6'b011111);  // as-is, rd -> 0
        check("R4 hand asis", int'(enc_word_o), 7'h1F);
        send("R6 drive neg2", 6'b111111);       // rd -> -5
        send("R4 neg rd zero word", 6'b000111); // inverted, rd -> -4
        check("R4 hand inv", int'(enc_word_o), 7'h78);
        send("R6 follow", 6'b110000);
    endtask

    task automatic t_bounds();
        do_reset();
        send("R7 to top", 6'b000000);           // rd 0 -> +7
        check("R7 top word", int'(enc_word_o), 7'h7F);
        send("R7 at top", 6'b000111);           // as-is, rd -> 6
        check("R7 top decision", int'(enc_word_o), 7'h07);
        do_reset();
        send("R7 prep", 6'b000111);             // rd -> 1
        send("R7 to bottom", 6'b000000);        // as-is, rd -> -6
        send("R7 at bottom", 6'b111111);        // as-is, rd -> -1
        check("R7 bottom decision", int'(enc_word_o), 7'h3F);
    endtask

    task automatic t_idle();
        do_reset();
        send("R8 prep", 6'b000001);             // rd -> 5
        idle(4);
        @(posedge clk);
        #1;
        check("R8 valid low", int'(enc_valid_o), 0);
        check("R8 word held", int'(enc_word_o), 7'h7E);
        send("R8 rd kept", 6'b000011);          // rd 5 still: as-is
        check("R8 hand", int'(enc_word_o), 7'h03);
    endtask

    task automatic t_bypass();
        do_reset();
        send("R9 prep", 6'b000001);             // rd -> 5
        bal_en = 1'b0;
        send("R9 bypass a", 6'b111111);
        check("R9 hand", int'(enc_word_o), 7'h3F);
        send("R9 bypass b", 6'b000000);
        bal_en = 1'b1;
        send("R9 rd frozen", 6'b000011);        // rd 5 still: as-is
        check("R9 hand2", int'(enc_word_o), 7'h03);
    endtask

    task automatic dec_send(input string req, input logic [W:0] w, input logic [W-1:0] exp);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_word_i  = w;
        @(posedge clk);
        #1;
        dec_valid_i = 1'b0;
        check({req, " valid"}, int'(dec_valid_o), 1);
        check(req, int'(dec_data_o), int'(exp));
    endtask

    task automatic t_decoder();
        do_reset();
        dec_send("R11 flag1", 7'b1_101100, 6'b010011);
        dec_send("R11 flag0", 7'b0_101100, 6'b101100);
        bal_en = 1'b0;
        dec_send("R11 disabled", 7'b1_101100, 6'b101100);
        bal_en = 1'b1;
    endtask

    task automatic t_stream();
        logic [15:0]  lfsr = 16'hACE1;
        logic [W:0]   prev_w = '0;
        logic [W-1:0] prev_d = '0;
        logic [W:0]   exp;
        logic [W-1:0] d;
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = lfsr[W-1:0];
            @(negedge clk);
            enc_valid_i = 1'b1;
            enc_data_i  = d;
            dec_valid_i = (i > 0);
            dec_word_i  = prev_w;
            exp = model(d);
            @(posedge clk);
            #1;
            check("R10 R6 stream enc", int'(enc_word_o), int'(exp));
            if (i > 0) check("R12 stream dec", int'(dec_data_o), int'(prev_d));
            prev_w = enc_word_o;
            prev_d = d;
        end
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_rules();
        t_bounds();
        t_idle();
        t_bypass();
        t_decoder();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule